// File: doc/BRIEF.md
# MDIO management frame engine

This block runs complete clause-22 management transactions on a two-wire management bus toward an external PHY. A host pulses a request together with the operation, a 5-bit PHY address, a 5-bit register number and, for a write, 16 data bits. The engine then drives the management clock, the serial data-out line and its output enable. During a read it samples the serial data-in line. At the end it returns the 16-bit read result with a one-cycle completion pulse.

A frame has six fields, each a state of the controlling state machine. `ST_IDLE` waits for a request. The transition *accept* (request seen while idle) enters `ST_PRE`. `ST_PRE` drives 32 bit times of ones, and *pre_end* moves to `ST_HDR`. `ST_HDR` sends the start code, the opcode, the PHY address and the register number, 14 bit times in all, and *hdr_end* moves to `ST_TA`. `ST_TA` releases the line for one bit time on a read and two on a write, and *ta_end* moves to `ST_DATA`. `ST_DATA` carries 16 bit times, either sampled or driven, and *data_end* moves to `ST_TAIL`. `ST_TAIL` is one released clock, and *tail_end* returns to `ST_IDLE` while raising the completion pulse. Each bit time is one low half-period followed by one high half-period. Each half lasts `HALF_DIV` system clocks. The default of 12500 gives 50 µs halves at a 250 MHz system clock.

Top module: `mdio_frame_engine`

## Requirements
- R1: Out of reset and whenever idle, `mdc_o`, `mdo_o`, `mdo_en_o`, `busy_o` and `done_o` are all 0.
- R2: Every frame starts with 32 bit times in which `mdo_en_o`=1 and `mdo_o`=1 at each rising clock edge.
- R3: Bit times 32–35 carry start code 0,1 and then the opcode. The opcode is 1,0 for a read (`op_wr_i`=0) and 0,1 for a write (`op_wr_i`=1), all with output enabled.
- R4: Bit times 36–40 carry the PHY address and bit times 41–45 the register number, each most significant bit first, with output enabled.
- R5: A read has exactly 64 rising clock edges. Bit times 46–63 (one turnaround, 16 input bits and one final clock) have `mdo_en_o`=0 and `mdo_o`=0.
- R6: A write has exactly 65 rising clock edges. Bit times 46–47 and 64 are released (`mdo_en_o`=0, `mdo_o`=0). Bit times 48–63 drive the write data most significant bit first with output enabled.
- R7: `mdo_o` and `mdo_en_o` change only while `mdc_o` is low, never during a high half.
- R8: Within a frame, each low half and each high half of `mdc_o` lasts exactly `HALF_DIV` system clocks.
- R9: On a read, `mdi_i` is sampled at the end of the high half of bit times 47–62. `rdata_o` holds those samples with bit time 47 in bit 15. After a write, `rdata_o` is 0.
- R10: `busy_o` is 1 from the cycle after the request is accepted until the frame ends. A request made while busy is ignored and leaves the running frame unchanged.
- R11: `done_o` is a single-cycle pulse in the cycle after the last high half. In that cycle `rdata_o` is valid and the bus is idle (clock low, data low, output released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a frame (taken only when idle) |
| op_wr_i | input | 1 | 1 = write, 0 = read |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register number |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read result |
| mdc_o | output | 1 | Management clock |
| mdo_o | output | 1 | Serial data out |
| mdo_en_o | output | 1 | Output enable for the data line |
| mdi_i | input | 1 | Serial data in |

## Verification
A field counter that slips, or a state that exits one bit early or late, moves every later bit. It changes the count of rising clock edges in the frame, so it shows at the end of the same frame as a wrong bit at a known index and a wrong edge total. A wrong half-period count shows in the first bit time, as a clock level of the wrong width. A sampling error, or an input shift with the wrong direction, shows on the next read as a wrong `rdata_o` at the completion pulse. Sweeping every PHY address with distinct register numbers and data, over both operations, exposes each bit position of each field.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 16;
    localparam int PRE_LEN = 32;
    localparam int HDR_LEN = 4 + 2 * ADDR_W;
    localparam int FCNT_MAX = (PRE_LEN > DATA_W) ?
                              ((PRE_LEN > HDR_LEN) ? PRE_LEN : HDR_LEN) :
                              ((DATA_W > HDR_LEN) ? DATA_W : HDR_LEN);
    localparam int FCNT_W  = $clog2(FCNT_MAX);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA,
        ST_TAIL
    } mdio_state_e;

endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
    parameter int HALF_DIV = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);

    generate
        if (HALF_DIV <= 1) begin : g_direct
            assign tick_o = run_i;
        end else begin : g_count
            localparam int CNT_W = $clog2(HALF_DIV);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);
            logic [CNT_W-1:0] cnt_q;

            assign tick_o = run_i && (cnt_q == LAST);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (!run_i || tick_o) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            AST_FIRST_HALF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(run_i) |-> !tick_o);  // R8
        end
    endgenerate

endmodule

// File: rtl/mdio_shift_out.sv
module mdio_shift_out
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              op_wr_i,
    input  logic [ADDR_W-1:0] phy_addr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              shift_hdr_i,
    input  logic              shift_dat_i,
    output logic              hdr_bit_o,
    output logic              dat_bit_o
);

    logic [HDR_LEN-1:0] hdr_q;
    logic [DATA_W-1:0]  dat_q;
    logic [1:0]         opcode;

    assign opcode    = op_wr_i ? 2'b01 : 2'b10;
    assign hdr_bit_o = hdr_q[HDR_LEN-1];
    assign dat_bit_o = dat_q[DATA_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q <= '0;
            dat_q <= '0;
        end else if (load_i) begin
            hdr_q <= {2'b01, opcode, phy_addr_i, reg_addr_i};
            dat_q <= wdata_i;
        end else begin
            if (shift_hdr_i) hdr_q <= {hdr_q[HDR_LEN-2:0], 1'b0};
            if (shift_dat_i) dat_q <= {dat_q[DATA_W-2:0], 1'b0};
        end
    end

    AST_NO_SHIFT_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !(shift_hdr_i || shift_dat_i));  // R10

endmodule

// File: rtl/mdio_shift_in.sv
module mdio_shift_in
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              sample_i,
    input  logic              mdi_i,
    input  logic              mdo_en_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] sh_q;

    assign rdata_o = sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (clear_i) begin
            sh_q <= '0;
        end else if (sample_i) begin
            sh_q <= {sh_q[DATA_W-2:0], mdi_i};
        end
    end

    AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i |-> !mdo_en_i);  // R9

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 12500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              op_wr_i,
    input  logic [ADDR_W-1:0] phy_addr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              mdc_o,
    output logic              mdo_o,
    output logic              mdo_en_o,
    input  logic              mdi_i
);

    localparam logic [FCNT_W-1:0] PRE_LAST  = FCNT_W'(PRE_LEN - 1);
    localparam logic [FCNT_W-1:0] HDR_LAST  = FCNT_W'(HDR_LEN - 1);
    localparam logic [FCNT_W-1:0] DATA_LAST = FCNT_W'(DATA_W - 1);

    mdio_state_e       state_q, state_d;
    logic              ph_q;
    logic [FCNT_W-1:0] fcnt_q;
    logic              op_wr_q;
    logic              done_q;

    logic              tick, bit_end, accept, field_end;
    logic [FCNT_W-1:0] ta_last;
    logic              hdr_bit, dat_bit;
    logic              shift_hdr, shift_dat, sample;

    assign busy_o  = (state_q != ST_IDLE);
    assign done_o  = done_q;
    assign accept  = (state_q == ST_IDLE) && req_i;
    assign bit_end = tick && ph_q;
    assign ta_last = op_wr_q ? FCNT_W'(1) : FCNT_W'(0);

    mdio_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy_o),
        .tick_o (tick)
    );

    mdio_shift_out u_txsh (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .op_wr_i     (op_wr_i),
        .phy_addr_i  (phy_addr_i),
        .reg_addr_i  (reg_addr_i),
        .wdata_i     (wdata_i),
        .shift_hdr_i (shift_hdr),
        .shift_dat_i (shift_dat),
        .hdr_bit_o   (hdr_bit),
        .dat_bit_o   (dat_bit)
    );

    mdio_shift_in u_rxsh (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .sample_i (sample),
        .mdi_i    (mdi_i),
        .mdo_en_i (mdo_en_o),
        .rdata_o  (rdata_o)
    );

    // Next-state logic: accept, pre_end, hdr_end, ta_end, data_end, tail_end
    always_comb begin
        state_d   = state_q;
        field_end = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req_i) state_d = ST_PRE;
            ST_PRE: if (bit_end && fcnt_q == PRE_LAST) begin
                state_d = ST_HDR;  field_end = 1'b1;
            end
            ST_HDR: if (bit_end && fcnt_q == HDR_LAST) begin
                state_d = ST_TA;   field_end = 1'b1;
            end
            ST_TA: if (bit_end && fcnt_q == ta_last) begin
                state_d = ST_DATA; field_end = 1'b1;
            end
            ST_DATA: if (bit_end && fcnt_q == DATA_LAST) begin
                state_d = ST_TAIL; field_end = 1'b1;
            end
            ST_TAIL: if (bit_end) begin
                state_d = ST_IDLE; field_end = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= 1'b0;
            fcnt_q  <= '0;
            op_wr_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_TAIL) && bit_end;
            if (accept) begin
                op_wr_q <= op_wr_i;
                ph_q    <= 1'b0;
                fcnt_q  <= '0;
            end else begin
                if (tick) ph_q <= ~ph_q;
                if (field_end) fcnt_q <= '0;
                else if (bit_end) fcnt_q <= fcnt_q + 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        mdc_o     = busy_o && ph_q;
        mdo_o     = 1'b0;
        mdo_en_o  = 1'b0;
        shift_hdr = 1'b0;
        shift_dat = 1'b0;
        sample    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PRE: begin
                mdo_en_o = 1'b1;
                mdo_o    = 1'b1;
            end
            ST_HDR: begin
                mdo_en_o  = 1'b1;
                mdo_o     = hdr_bit;
                shift_hdr = bit_end;
            end
            ST_TA: ;
            ST_DATA: begin
                if (op_wr_q) begin
                    mdo_en_o  = 1'b1;
                    mdo_o     = dat_bit;
                    shift_dat = bit_end;
                end else begin
                    sample = bit_end;
                end
            end
            ST_TAIL: ;
            default: ;
        endcase
    end

    AST_IDLE_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        mdc_o |-> busy_o);  // R1
    AST_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_o && $past(mdc_o)) |-> ($stable(mdo_o) && $stable(mdo_en_o)));  // R7
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);  // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);  // R11
    AST_DONE_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!mdc_o && !mdo_o && !mdo_en_o));  // R11

endmodule

// File: tb/mdio_frame_engine_tb.sv
module mdio_frame_engine_tb;

    localparam int HD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        op_wr_i = 1'b0;
    logic [4:0]  phy_addr_i = '0;
    logic [4:0]  reg_addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic        busy_o, done_o, mdc_o, mdo_o, mdo_en_o;
    logic [15:0] rdata_o;
    logic        mdi_i = 1'b0;

    always #2 clk = ~clk;

    mdio_frame_engine #(.HALF_DIV(HD)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_wr_i(op_wr_i),
        .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
        .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
        .mdc_o(mdc_o), .mdo_o(mdo_o), .mdo_en_o(mdo_en_o), .mdi_i(mdi_i)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit timed_out = 0;

    logic        cur_wr;
    logic [15:0] cur_rv;
    int          nbits;
    logic        rec_oe [0:79];
    logic        rec_do [0:79];
    int          width_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                timed_out = 1;
                chk(0, "WATCHDOG", cycles, 150000);
                finish_run();
            end
        end
    end

    // PHY model: record bits at each rise, present read data for that bit
    initial begin
        forever begin
            @(posedge mdc_o);
            #1;
            if (nbits < 80) begin
                rec_oe[nbits] = mdo_en_o;
                rec_do[nbits] = mdo_o;
            end
            if (!cur_wr && nbits >= 47 && nbits <= 62)
                mdi_i = cur_rv[62 - nbits];
            else
                mdi_i = ~nbits[0];
            nbits++;
        end
    end

    // Half-period width monitor (R8)
    initial begin
        logic pm, pb;
        int run;
        pm = 0; pb = 0; run = 0;
        forever begin
            @(negedge clk);
            if (busy_o && !pb) run = 1;
            else if (pb && mdc_o != pm) begin
                if (run != HD) width_bad++;
                run = 1;
            end else if (busy_o) run++;
            pm = mdc_o;
            pb = busy_o;
        end
    end

    function automatic logic [1:0] exp_bit(int k, logic wr, logic [4:0] a,
                                           logic [4:0] r, logic [15:0] d);
        if (k < 32) return 2'b11;
        if (k == 32) return 2'b10;
        if (k == 33) return 2'b11;
        if (k == 34) return wr ? 2'b10 : 2'b11;
        if (k == 35) return wr ? 2'b11 : 2'b10;
        if (k <= 40) return {1'b1, a[40 - k]};
        if (k <= 45) return {1'b1, r[45 - k]};
        if (!wr) return 2'b00;
        if (k <= 47) return 2'b00;
        if (k <= 63) return {1'b1, d[63 - k]};
        return 2'b00;
    endfunction

    task automatic run_frame(input logic wr, input logic [4:0] a, input logic [4:0] r,
                             input logic [15:0] d, input logic [15:0] rv, input bit poke);
        int wb0, waitc, dcnt;
        int e_pre, e_hdr, e_opc, e_tail, e_wd;
        logic [1:0] e;
        wb0 = width_bad;
        cur_wr = wr; cur_rv = rv; nbits = 0;
        @(negedge clk);
        req_i = 1; op_wr_i = wr; phy_addr_i = a; reg_addr_i = r; wdata_i = d;
        @(negedge clk);
        req_i = 0; op_wr_i = ~wr; phy_addr_i = ~a; reg_addr_i = ~r; wdata_i = ~d;
        chk(busy_o == 1'b1, "R10 busy after accept", busy_o, 1);
        waitc = 0;
        while (!done_o && !timed_out) begin
            @(negedge clk);
            waitc++;
            if (poke && waitc == 150) req_i = 1;
            if (poke && waitc == 152) req_i = 0;
            if (!done_o && !busy_o) begin
                chk(0, "R10 busy dropped early", busy_o, 1);
                break;
            end
        end
        // done cycle
        chk(!mdc_o && !mdo_o && !mdo_en_o, "R11 bus idle at done",
            {mdc_o, mdo_o, mdo_en_o}, 0);
        chk(rdata_o == (wr ? 16'h0 : rv), wr ? "R9 rdata zero after write" : "R9 read data",
            rdata_o, wr ? 0 : rv);
        chk(nbits == (wr ? 65 : 64), wr ? "R6 write clock count" : "R5 read clock count",
            nbits, wr ? 65 : 64);
        dcnt = 0;
        @(negedge clk);
        chk(!done_o && !busy_o, "R11 done single pulse", {done_o, busy_o}, 0);
        e_pre = 0; e_hdr = 0; e_opc = 0; e_tail = 0; e_wd = 0;
        for (int k = 0; k < nbits && k < 80; k++) begin
            e = exp_bit(k, wr, a, r, d);
            if ({rec_oe[k], rec_do[k]} != e) begin
                if (k < 32) e_pre++;
                else if (k < 36) e_opc++;
                else if (k < 46) e_hdr++;
                else if (wr && k >= 48 && k <= 63) e_wd++;
                else e_tail++;
            end
        end
        chk(e_pre == 0, "R2 preamble bits", e_pre, 0);
        chk(e_opc == 0, "R3 start and opcode", e_opc, 0);
        chk(e_hdr == 0, "R4 address and register", e_hdr, 0);
        if (wr) chk(e_wd == 0, "R6 write data bits", e_wd, 0);
        chk(e_tail == 0, wr ? "R6 released bits" : "R5 released bits", e_tail, 0);
        chk(width_bad == wb0, "R8 half period width", width_bad - wb0, 0);
        if (poke) chk(nbits == (wr ? 65 : 64), "R10 request while busy ignored", nbits, wr ? 65 : 64);
        chk(!mdc_o && !mdo_en_o && !mdo_o, "R1 idle after frame", {mdc_o, mdo_en_o, mdo_o}, 0);
    endtask

    initial begin
        cur_wr = 0; cur_rv = 0; nbits = 0;
        repeat (3) @(negedge clk);
        chk({mdc_o, mdo_o, mdo_en_o, busy_o, done_o} == 5'b0, "R1 reset outputs",
            {mdc_o, mdo_o, mdo_en_o, busy_o, done_o}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk({mdc_o, mdo_o, mdo_en_o, busy_o, done_o} == 5'b0, "R1 idle after reset",
            {mdc_o, mdo_o, mdo_en_o, busy_o, done_o}, 0);
        // R7 is also observed: recorded bits taken at each rise must match
        for (int i = 0; i < 32; i++) begin
            logic [4:0]  a  = 5'(i);
            logic [4:0]  r  = 5'((i * 7 + 3) % 32);
            logic [15:0] d  = 16'(i * 16'h0841) ^ 16'h5A3C;
            logic [15:0] rv = 16'(i * 16'h1357) ^ 16'hC3A5;
            run_frame(i[0], a, r, d, rv, 1'b0);
        end
        run_frame(1'b0, 5'h1F, 5'h1F, 16'h0000, 16'hFFFF, 1'b0);
        run_frame(1'b1, 5'h1F, 5'h1F, 16'hFFFF, 16'h0000, 1'b0);
        run_frame(1'b0, 5'h00, 5'h00, 16'hFFFF, 16'h0001, 1'b0);
        run_frame(1'b1, 5'h00, 5'h00, 16'h8000, 16'h8000, 1'b0);
        run_frame(1'b0, 5'h15, 5'h0A, 16'h1234, 16'hBEEF, 1'b1);
        run_frame(1'b1, 5'h0A, 5'h15, 16'hA55A, 16'h0000, 1'b1);
        finish_run();
    end

endmodule